// File: doc/BRIEF.md
# Nibble-Safe SEC-DED Codec for a 32-bit Memory Word

This block protects a 32-bit data word kept in memory as a 40-bit codeword that carries 8 check bits. On the write side, a combinational encoder forms the check bits, so the stored word is ready in the cycle the data is presented. On the read side, the 40-bit word from memory passes through a syndrome computation and a correction step. The outcome is captured in one register stage, which gives exactly one cycle of read latency.

The code corrects any single flipped bit and detects any two flipped bits. It also detects every corruption that stays inside one aligned group of four codeword bits. The check matrix is built so that each column's low syndrome half is a one-hot tag for the bit's place inside its group. The high half tells the groups apart. When an error is detected but cannot be corrected, the word is passed on raw and a flag is raised. An enable input lets reads skip checking while keeping the same one-cycle timing.

Top module: `ecc_nibble_secded`

## Requirements
- R1: The encoder is combinational. In the same cycle, `wr_code[39:8]` equals `wr_data` and `wr_code[7:0]` holds the check bits, with no register on the path.
- R2: With `ecc_en` high, an unmodified codeword read back yields the original data, with `rd_corrected` and `rd_uncorrectable` both low.
- R3: With `ecc_en` high, a codeword with exactly one flipped bit at any of the 40 positions (check bits included) yields the original data and raises `rd_corrected` only.
- R4: With `ecc_en` high, any two flipped bits anywhere in the codeword raise `rd_uncorrectable` only. `rd_data` then equals the received bits 39:8, unmodified.
- R5: With `ecc_en` high, any error of two, three or four flipped bits confined to one aligned group (codeword bits 4k to 4k+3) raises `rd_uncorrectable` only, and the received data is passed through.
- R6: Read results are registered. They appear on the outputs one clock edge after `rd_code` and `ecc_en` are sampled, and they do not change before that edge.
- R7: With `ecc_en` low, `rd_data` equals the received bits 39:8 with no correction, both flags stay low, and the latency is still one cycle.
- R8: While `rst` is high at a clock edge, `rd_data`, `rd_corrected` and `rd_uncorrectable` become zero.
- R9: `rd_corrected` and `rd_uncorrectable` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_en | input | 1 | Enables checking and correction on the read path |
| wr_data | input | 32 | Data to be written |
| wr_code | output | 40 | Codeword to store: data in bits 39:8, check bits in 7:0 |
| rd_code | input | 40 | Codeword read from memory |
| rd_data | output | 32 | Registered, possibly corrected, read data |
| rd_corrected | output | 1 | A single-bit error was corrected in this word |
| rd_uncorrectable | output | 1 | An error was detected that could not be corrected |

## Verification
The encoder result is due in the same cycle as `wr_data`, so the bench reads `wr_code` after a short settling delay, before any clock edge. Read results are due one rising edge after `rd_code` is driven. Inputs change on the falling edge, and outputs are sampled on the next falling edge, with one extra probe just before the edge to confirm that nothing arrives early. Single, double and in-group error sweeps cover every position and pair. The expected data is derived from the error class alone: the original word when the error is corrected, the raw received bits otherwise.

// File: rtl/ecc_nib_pkg.sv
package ecc_nib_pkg;

    localparam int DATA_W  = 32;
    localparam int CHK_W   = 8;
    localparam int CODE_W  = DATA_W + CHK_W;
    localparam int GRP_W   = 4;
    localparam int NUM_GRP = CODE_W / GRP_W;
    localparam int HALF_W  = CHK_W / 2;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CHK_W-1:0]  syn_t;
    typedef logic [HALF_W-1:0] half_t;

    typedef enum logic [1:0] {
        RD_CLEAN = 2'd0,
        RD_FIXED = 2'd1,
        RD_FATAL = 2'd2
    } rd_class_e;

    typedef struct packed {
        data_t     data;
        rd_class_e kind;
    } rd_result_t;

    // Group identifier placed in the upper syndrome half. Group 0 uses zero
    // and group 1 uses a one-hot value, so both check groups solve trivially.
    // The data groups use non-zero, non-one-hot values.
    function automatic half_t group_tag(input int grp, input int pos);
        half_t t;
        case (grp)
            0:       t = '0;
            1:       t = half_t'(1 << pos);
            2:       t = 4'd3;
            3:       t = 4'd5;
            4:       t = 4'd6;
            5:       t = 4'd7;
            6:       t = 4'd9;
            7:       t = 4'd10;
            8:       t = 4'd11;
            default: t = 4'd12;
        endcase
        return t;
    endfunction

    // Column of the check matrix for codeword bit idx.
    function automatic syn_t column(input int idx);
        int grp;
        int pos;
        grp = idx / GRP_W;
        pos = idx % GRP_W;
        return {group_tag(grp, pos), half_t'(1 << pos)};
    endfunction

    function automatic syn_t syndrome_of(input code_t cw);
        syn_t s;
        s = '0;
        for (int i = 0; i < CODE_W; i++) begin
            if (cw[i]) s ^= column(i);
        end
        return s;
    endfunction

endpackage

// File: rtl/ecc_nib_encoder.sv
module ecc_nib_encoder
    import ecc_nib_pkg::*;
(
    input  data_t data_i,
    output code_t code_o
);
    syn_t data_syn;

    always_comb begin
        data_syn = syndrome_of({data_i, {CHK_W{1'b0}}});
        // Upper check group cancels the upper half; lower group fixes the rest.
        code_o = {data_i,
                  data_syn[CHK_W-1:HALF_W],
                  data_syn[HALF_W-1:0] ^ data_syn[CHK_W-1:HALF_W]};
    end
endmodule

// File: rtl/ecc_nib_syndrome.sv
module ecc_nib_syndrome
    import ecc_nib_pkg::*;
(
    input  code_t code_i,
    output syn_t  syn_o
);
    always_comb syn_o = syndrome_of(code_i);
endmodule

// File: rtl/ecc_nib_corrector.sv
module ecc_nib_corrector
    import ecc_nib_pkg::*;
(
    input  code_t      code_i,
    input  syn_t       syn_i,
    output rd_result_t res_o
);
    code_t flip_mask;
    code_t fixed;

    for (genvar i = 0; i < CODE_W; i++) begin : g_col
        assign flip_mask[i] = (syn_i == column(i));
    end

    always_comb begin
        fixed      = code_i ^ flip_mask;
        res_o.data = fixed[CODE_W-1:CHK_W];
        if (syn_i == '0) begin
            res_o.kind = RD_CLEAN;
        end else if (|flip_mask) begin
            res_o.kind = RD_FIXED;
        end else begin
            res_o.kind = RD_FATAL;
            res_o.data = code_i[CODE_W-1:CHK_W];
        end
    end
endmodule

// File: rtl/ecc_nibble_secded.sv
module ecc_nibble_secded
    import ecc_nib_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ecc_en,
    input  logic [31:0] wr_data,
    output logic [39:0] wr_code,
    input  logic [39:0] rd_code,
    output logic [31:0] rd_data,
    output logic        rd_corrected,
    output logic        rd_uncorrectable
);
    syn_t       rd_syn;
    rd_result_t chk_res;
    rd_result_t next_res;
    rd_result_t res_q;

    ecc_nib_encoder u_enc (
        .data_i (wr_data),
        .code_o (wr_code)
    );

    ecc_nib_syndrome u_syn (
        .code_i (rd_code),
        .syn_o  (rd_syn)
    );

    ecc_nib_corrector u_fix (
        .code_i (rd_code),
        .syn_i  (rd_syn),
        .res_o  (chk_res)
    );

    always_comb begin
        if (ecc_en) begin
            next_res = chk_res;
        end else begin
            next_res.data = rd_code[CODE_W-1:CHK_W];
            next_res.kind = RD_CLEAN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q.data <= '0;
            res_q.kind <= RD_CLEAN;
        end else begin
            res_q <= next_res;
        end
    end

    assign rd_data          = res_q.data;
    assign rd_corrected     = (res_q.kind == RD_FIXED);
    assign rd_uncorrectable = (res_q.kind == RD_FATAL);
endmodule

// File: rtl/ecc_nibble_secded_chk.sv
module ecc_nibble_secded_chk (
    input logic        clk,
    input logic        rst,
    input logic        ecc_en,
    input logic [31:0] wr_data,
    input logic [39:0] wr_code,
    input logic [39:0] rd_code,
    input logic [31:0] rd_data,
    input logic        rd_corrected,
    input logic        rd_uncorrectable
);
    // R1
    always_comb begin
        enc_passthru_chk: assert (wr_code[39:8] === wr_data || $isunknown(wr_data));
    end

    // R9
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_corrected, rd_uncorrectable}));

    // R7
    bypass_raw_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ecc_en)) |->
            (rd_data == $past(rd_code[39:8]) && !rd_corrected && !rd_uncorrectable));

    // R2
    roundtrip_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ecc_en) && $past(rd_code) == $past(wr_code)) |->
            (rd_data == $past(wr_data) && !rd_corrected && !rd_uncorrectable));

    // R4
    fatal_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        rd_uncorrectable |-> rd_data == $past(rd_code[39:8]));

    // R3
    fix_one_bit_chk: assert property (@(posedge clk) disable iff (rst)
        rd_corrected |-> $countones(rd_data ^ $past(rd_code[39:8])) <= 1);
endmodule

bind ecc_nibble_secded ecc_nibble_secded_chk u_chk (.*);

// File: tb/tb_ecc_nibble_secded.sv
`timescale 1ns/1ps
module tb_ecc_nibble_secded;

    logic        clk = 1'b0;
    logic        rst;
    logic        ecc_en;
    logic [31:0] wr_data;
    logic [39:0] wr_code;
    logic [39:0] rd_code;
    logic [31:0] rd_data;
    logic        rd_corrected;
    logic        rd_uncorrectable;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;

    ecc_nibble_secded dut (
        .clk              (clk),
        .rst              (rst),
        .ecc_en           (ecc_en),
        .wr_data          (wr_data),
        .wr_code          (wr_code),
        .rd_code          (rd_code),
        .rd_data          (rd_data),
        .rd_corrected     (rd_corrected),
        .rd_uncorrectable (rd_uncorrectable)
    );

    // kind: 0 clean, 1 corrected, 2 uncorrectable
    localparam int NVEC = 12;
    localparam logic [31:0] V_DATA [NVEC] = '{
        32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_A5A5, 32'h1234_5678,
        32'hDEAD_BEEF, 32'h0F0F_0F0F, 32'h1357_9BDF, 32'h2468_ACE0,
        32'hC3C3_C3C3, 32'h55AA_55AA, 32'h0000_0001, 32'h8000_0000};
    localparam logic [39:0] V_MASK [NVEC] = '{
        40'h0, 40'h0, 40'h0, 40'h1,
        40'h80_0000_0000, 40'h80, 40'h3, 40'hF0_0000_0000,
        40'h0E00, 40'h10_0000_0001, 40'h100, 40'h00_F000_0000};
    localparam int V_KIND [NVEC] = '{0, 0, 0, 1, 1, 1, 2, 2, 2, 2, 1, 2};

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drives one read, samples one edge later, compares with the class.
    task automatic run_vec(input logic [31:0] d, input logic [39:0] m,
                           input int kind, input logic en, input string req);
        logic [31:0] exp_d;
        @(negedge clk);
        wr_data = d;
        ecc_en  = en;
        #1;
        check(wr_code[39:8] == d, "R1", 64'(wr_code[39:8]), 64'(d));
        rd_code = wr_code ^ m;
        @(negedge clk);
        exp_d = (en && kind != 2) ? d : (d ^ m[39:8]);
        check(rd_data == exp_d, req, 64'(rd_data), 64'(exp_d));
        check(rd_corrected == (en && kind == 1), req,
              64'(rd_corrected), 64'(en && kind == 1));
        check(rd_uncorrectable == (en && kind == 2), req,
              64'(rd_uncorrectable), 64'(en && kind == 2));
        check(!(rd_corrected && rd_uncorrectable), "R9",
              64'({rd_corrected, rd_uncorrectable}), 64'(0));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] seed;
        rst = 1'b1; ecc_en = 1'b1; wr_data = '0; rd_code = 40'hFF_FFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8 reset state
        check(rd_data == 0 && !rd_corrected && !rd_uncorrectable, "R8",
              64'({rd_data, rd_corrected, rd_uncorrectable}), 64'(0));
        rst = 1'b0;

        // Vector table: R2 clean, R3 single, R4 double, R5 in-group
        for (int v = 0; v < NVEC; v++)
            run_vec(V_DATA[v], V_MASK[v], V_KIND[v], 1'b1,
                    V_KIND[v] == 0 ? "R2" : (V_KIND[v] == 1 ? "R3" : "R5"));

        // R3: every single-bit position
        for (int i = 0; i < 40; i++)
            run_vec(32'h9E37_79B9 ^ 32'(i * 32'h0101_0101), 40'h1 << i, 1, 1'b1, "R3");

        // R5: every multi-bit pattern inside every aligned group
        for (int g = 0; g < 10; g++)
            for (int p = 1; p < 16; p++)
                if ($countones(p) >= 2)
                    run_vec(32'hC001_D00D + 32'(g * 16 + p),
                            40'(p) << (4 * g), 2, 1'b1, "R5");

        // R4: every pair of bits
        seed = 32'h1F2E_3D4C;
        for (int i = 0; i < 40; i++)
            for (int j = i + 1; j < 40; j++) begin
                seed = seed * 32'd1664525 + 32'd1013904223;
                run_vec(seed, (40'h1 << i) | (40'h1 << j), 2, 1'b1, "R4");
            end

        // R7: bypass, errors pass raw, flags low
        run_vec(32'hCAFE_F00D, 40'h0, 0, 1'b0, "R7");
        run_vec(32'hCAFE_F00D, 40'h1_0000, 1, 1'b0, "R7");
        run_vec(32'h7777_0000, 40'h3, 2, 1'b0, "R7");

        // R6: nothing changes before the edge, result arrives after it
        run_vec(32'h1111_1111, 40'h0, 0, 1'b1, "R6");
        @(negedge clk);
        wr_data = 32'h2222_2222; ecc_en = 1'b1;
        #1;
        rd_code = wr_code ^ 40'h4_0000_0000;
        #2;
        check(rd_data == 32'h1111_1111 && !rd_corrected, "R6",
              64'(rd_data), 64'h1111_1111);
        @(negedge clk);
        check(rd_data == 32'h2222_2222 && rd_corrected, "R6",
              64'({rd_data, rd_corrected}), 64'({32'h2222_2222, 1'b1}));

        // R8: reset mid-run clears the outputs
        run_vec(32'hABCD_EF01, 40'h3, 2, 1'b1, "R5");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(rd_data == 0 && !rd_corrected && !rd_uncorrectable, "R8",
              64'({rd_data, rd_corrected, rd_uncorrectable}), 64'(0));
        rst = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule